// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a synchronous SRAM, 18 bits wide and flow-through, that needs no idle cycle when a read follows a write or a write follows a read. Each word holds 16 data bits and 2 parity bits. All control inputs, the address and the write data are sampled on the rising clock edge. An active-low clock enable gates every edge. When it is high, the edge has no effect on any state.

The data path uses split ports instead of a tristate bus. Write data enters on `wdata`. Read data leaves on `rdata`, and `dq_oe` marks the cycles in which a driver outside the block should put `rdata` on a shared bus. A write takes its address on one edge and its data and byte selects on the next edge. A read shows the addressed word in the cycle after its address edge, with no output register in the path.

Holding `adv_ld_n` high continues a burst of four words. The burst keeps the same operation and steps the two low address bits, in linear order or in interleaved order. The control core is a three-state machine:

- `ST_DESEL`: the device is deselected.
- `ST_READ`: a read address is active.
- `ST_WRITE`: a write address is active and waits for its data edge.

The transitions are:

- LOAD_RD: any state goes to `ST_READ` on an enabled load edge with the chip selected and `we_n` high.
- LOAD_WR: any state goes to `ST_WRITE` on an enabled load edge with the chip selected and `we_n` low.
- LOAD_DESEL: any state goes to `ST_DESEL` on an enabled load edge with the chip not selected.
- ADVANCE: `ST_READ` or `ST_WRITE` keeps its state and steps the burst counter.
- IDLE_ADV: `ST_DESEL` stays deselected on an advance edge.
- STALL: every state holds while `cen_n` is high.

Top module: `sram_ft`

## Requirements
- R1: After reset the state is `ST_DESEL` and `dq_oe` is 0. A write whose address edge came before the reset does not update memory.
- R2: A new access starts at an edge only when all of these hold: `cen_n`=0, `adv_ld_n`=0, `ce1_n`=0, `ce2`=1 and `ce3_n`=0. At that edge `addr` is latched, and `we_n`=0 selects a write while `we_n`=1 selects a read.
- R3: On an enabled edge with `adv_ld_n`=0, if any one chip enable is inactive (`ce1_n`=1, `ce2`=0 or `ce3_n`=1), the device enters `ST_DESEL` and `dq_oe` is 0 in the following cycle.
- R4: In the cycle after a read address edge, `rdata` equals the stored word at that address, with no extra register stage.
- R5: A write takes `wdata` and `bws_n` at the edge after its address edge, and memory is updated at that edge. A read latched at that same edge returns the new word in the next cycle.
- R6: Byte selects are active low. `bws_n[0]`=0 writes `wdata[7:0]` and parity bit `wdata[16]`. `bws_n[1]`=0 writes `wdata[15:8]` and parity bit `wdata[17]`. A lane whose select is 1 keeps its stored bits.
- R7: While `cen_n`=1 the edge is ignored: state, burst position and memory all hold, and `rdata` holds its value.
- R8: `dq_oe` is 0 while a write address is active (the write data cycle), and also whenever `oe_n`=1.
- R9: In the first cycle after an enabled edge taken from `ST_DESEL`, `dq_oe` is 0 even when `oe_n`=0 and a read is active.
- R10: With `mode`=0 (linear order), each advance edge adds 1 modulo 4 to the two low address bits, so the start sequence 2 gives 2, 3, 0, 1.
- R11: With `mode`=1 (interleaved order), the low address bits equal the start bits XOR a counter running 0, 1, 2, 3, so start 1 gives 1, 0, 3, 2.
- R12: An enabled edge with `adv_ld_n`=1 taken in `ST_DESEL` leaves the device deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; inputs are sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cen_n | input | 1 | Clock enable, active low; when high, the edge is ignored |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_ld_n | input | 1 | Low loads a new address; high advances the burst |
| we_n | input | 1 | Low selects a write at a load edge |
| bws_n | input | 2 | Byte-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| mode | input | 1 | Burst order: 1 interleaved, 0 linear; held constant |
| oe_n | input | 1 | Output enable, active low, not registered |
| wdata | input | 18 | Write word: [15:0] data, [17:16] parity |
| rdata | output | 18 | Read word, flow-through from the current address |
| dq_oe | output | 1 | High when the read word should be driven |

## Verification
The assertions take two things for granted:

- `mode` does not change within a burst.
- `cen_n` is high whenever `rst_n` is low, so no load is attempted during reset.

The stimulus changes `mode` only at load edges and holds the clock enable off around every reset pulse. The bench also compares `rdata` only in cycles where `dq_oe` is expected high, and only at addresses it has already written. This keeps the bench from relying on the power-up contents of memory.

// File: rtl/sram_ft_pkg.sv
package sram_ft_pkg;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } op_state_e;

    localparam int LANES     = 2;
    localparam int LANE_DATA = 8;
    localparam int DATA_W    = LANES * LANE_DATA;
    localparam int WORD_W    = DATA_W + LANES;
    localparam int LANE_W    = LANE_DATA + 1;
    localparam int BURST_W   = 2;

endpackage

// File: rtl/sram_ft_burst.sv
module sram_ft_burst
    import sram_ft_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load,
    input  logic              step,
    input  logic              mode,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0]  base_q;
    logic [BURST_W-1:0] cnt_q;
    logic [BURST_W-1:0] low;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            if (load) begin
                base_q <= addr_in;
                cnt_q  <= '0;
            end else if (step) begin
                cnt_q <= cnt_q + 2'd1;
            end
        end
    end

    always_comb begin
        if (mode) low = base_q[BURST_W-1:0] ^ cnt_q;
        else      low = base_q[BURST_W-1:0] + cnt_q;
        cur_addr = {base_q[ADDR_W-1:BURST_W], low};
    end

    // R2: a load edge puts the sampled address on the array
    a_r2_load_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> cur_addr == $past(addr_in));

    // R10: linear order steps the low bits by one
    a_r10_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && step && !mode) |=>
        cur_addr[BURST_W-1:0] == $past(cur_addr[BURST_W-1:0]) + 2'd1);

    // R11: interleaved order keeps high bits, low bits are base xor count
    a_r11_interleave: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load && step && mode) |=>
        ((cur_addr[BURST_W-1:0] ^ base_q[BURST_W-1:0]) == $past(cnt_q) + 2'd1)
        && cur_addr[ADDR_W-1:BURST_W] == $past(cur_addr[ADDR_W-1:BURST_W]));

endmodule

// File: rtl/sram_ft_array.sv
module sram_ft_array
    import sram_ft_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] lane_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && lane_en[g])
                mem[addr] <= {wdata[DATA_W+g], wdata[g*LANE_DATA +: LANE_DATA]};
        end

        assign lane_q[g] = mem[addr];
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < LANES; i++) begin
            rdata[i*LANE_DATA +: LANE_DATA] = lane_q[i][LANE_DATA-1:0];
            rdata[DATA_W+i]                 = lane_q[i][LANE_DATA];
        end
    end

endmodule

// File: rtl/sram_ft_ctrl.sv
module sram_ft_ctrl
    import sram_ft_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cen_n,
    input  logic      ce_all,
    input  logic      adv_ld_n,
    input  logic      we_n,
    input  logic      oe_n,
    output logic      en,
    output logic      load,
    output logic      step,
    output logic      wr_en,
    output op_state_e state,
    output logic      dq_oe
);

    op_state_e state_n;
    logic      first_q;

    assign en = !cen_n;

    always_comb begin
        load  = en && !adv_ld_n && ce_all;
        step  = en && adv_ld_n && (state != ST_DESEL);
        wr_en = en && (state == ST_WRITE);
    end

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_DESEL: begin
                if (load) state_n = we_n ? ST_READ : ST_WRITE;  // LOAD_RD / LOAD_WR
            end                                                 // IDLE_ADV, LOAD_DESEL hold
            ST_READ, ST_WRITE: begin
                if (load)
                    state_n = we_n ? ST_READ : ST_WRITE;
                else if (en && !adv_ld_n)
                    state_n = ST_DESEL;                         // LOAD_DESEL
            end                                                 // ADVANCE keeps state
            default: state_n = ST_DESEL;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_DESEL;
            first_q <= 1'b0;
        end else if (en) begin
            state   <= state_n;
            first_q <= (state == ST_DESEL);
        end
    end

    // outputs
    always_comb begin
        dq_oe = !oe_n && (state == ST_READ) && !first_q;
    end

    // R7: a stalled edge changes nothing
    a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(state) && $stable(first_q));

    // R3: load with any chip enable inactive deselects and drops drive
    a_r3_desel_load: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !adv_ld_n && !ce_all) |=> (state == ST_DESEL) && !dq_oe);

    // R12: advance while deselected stays deselected
    a_r12_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (en && adv_ld_n && state == ST_DESEL) |=> state == ST_DESEL);

    // R8: no drive in the cycle after a write load
    a_r8_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !we_n) |=> !dq_oe);

    // R9: no drive on the first cycle out of deselect
    a_r9_first_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == ST_DESEL) |=> !dq_oe);

    // R2: a load selects the operation from we_n
    a_r2_op_select: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> state == ($past(we_n) ? ST_READ : ST_WRITE));

endmodule

// File: rtl/sram_ft.sv
module sram_ft
    import sram_ft_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              adv_ld_n,
    input  logic              we_n,
    input  logic [1:0]        bws_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode,
    input  logic              oe_n,
    input  logic [17:0]       wdata,
    output logic [17:0]       rdata,
    output logic              dq_oe
);

    logic              ce_all;
    logic              en;
    logic              load;
    logic              step;
    logic              wr_en;
    op_state_e         state;
    logic [ADDR_W-1:0] cur_addr;

    assign ce_all = !ce1_n && ce2 && !ce3_n;

    sram_ft_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cen_n    (cen_n),
        .ce_all   (ce_all),
        .adv_ld_n (adv_ld_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .en       (en),
        .load     (load),
        .step     (step),
        .wr_en    (wr_en),
        .state    (state),
        .dq_oe    (dq_oe)
    );

    sram_ft_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .load     (load),
        .step     (step),
        .mode     (mode),
        .addr_in  (addr),
        .cur_addr (cur_addr)
    );

    sram_ft_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .wr_en    (wr_en),
        .lane_en  (~bws_n),
        .addr     (cur_addr),
        .wdata    (wdata),
        .rdata    (rdata)
    );

    // R1: reset leaves the device deselected with drive off
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> !dq_oe);

    // R7: a stalled edge keeps the read word
    a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_n && $stable(mode)) |=> $stable(rdata));

    // R8: output enable high always removes drive
    a_r8_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);

endmodule

// File: tb/tb_sram_ft.sv
module tb_sram_ft;

    localparam int AW = 6;
    localparam logic [2:0] ON = 3'b010;   // {ce1_n, ce2, ce3_n} all active

    typedef struct packed {
        logic [3:0]  req;
        logic        cen_n;
        logic [2:0]  ce;
        logic        adv;
        logic        we_n;
        logic [1:0]  bws;
        logic        oe_n;
        logic        mode;
        logic [5:0]  a;
        logic [17:0] wd;
    } vec_t;

    localparam int NV = 31;
    localparam vec_t VEC [NV] = '{
        // R2 write burst, interleaved from 6 -> 6,7,4,5 (R11)
        '{4'd2,  1'b0, ON,     1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 6'd6,  18'h00000},
        '{4'd8,  1'b0, ON,     1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 6'd0,  18'h01111},
        '{4'd8,  1'b0, ON,     1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 6'd0,  18'h12222},
        '{4'd8,  1'b0, ON,     1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 6'd0,  18'h23333},
        // R4 read right after write, no idle cycle (R5)
        '{4'd4,  1'b0, ON,     1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 6'd6,  18'h34444},
        '{4'd11, 1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 6'd0,  18'h00000},
        '{4'd11, 1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 6'd0,  18'h00000},
        '{4'd11, 1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 6'd0,  18'h00000},
        '{4'd11, 1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 6'd0,  18'h00000},
        // R5 write then read of the same word
        '{4'd5,  1'b0, ON,     1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 6'd20, 18'h00000},
        '{4'd5,  1'b0, ON,     1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 6'd20, 18'h2ABCD},
        // R6 upper lane only
        '{4'd6,  1'b0, ON,     1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 6'd20, 18'h00000},
        '{4'd6,  1'b0, ON,     1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 6'd20, 18'h15500},
        // R10 linear write burst from 32
        '{4'd8,  1'b0, ON,     1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 6'd32, 18'h00000},
        '{4'd10, 1'b0, ON,     1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00A01},
        '{4'd10, 1'b0, ON,     1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00A02},
        '{4'd10, 1'b0, ON,     1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00A03},
        '{4'd10, 1'b0, ON,     1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 6'd34, 18'h00A04},
        '{4'd10, 1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00000},
        // R7 stall mid-burst with busy inputs
        '{4'd7,  1'b1, ON,     1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 6'd1,  18'h3FFFF},
        '{4'd7,  1'b1, 3'b101, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 6'd9,  18'h3FFFF},
        '{4'd10, 1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00000},
        '{4'd10, 1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00000},
        // R3 deselect via ce2, R12 advance while deselected
        '{4'd3,  1'b0, 3'b000, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00000},
        '{4'd12, 1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00000},
        // R9 first read out of deselect is masked
        '{4'd9,  1'b0, ON,     1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 6'd33, 18'h00000},
        '{4'd9,  1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00000},
        // R8 oe_n high, then write data cycle
        '{4'd8,  1'b0, ON,     1'b1, 1'b1, 2'b00, 1'b1, 1'b0, 6'd0,  18'h00000},
        '{4'd8,  1'b0, ON,     1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 6'd7,  18'h00000},
        '{4'd5,  1'b0, ON,     1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 6'd7,  18'h3C3C3},
        '{4'd3,  1'b0, 3'b000, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 6'd0,  18'h00000}
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cen_n, ce1_n, ce2, ce3_n, adv_ld_n, we_n, mode, oe_n;
    logic [1:0]    bws_n;
    logic [AW-1:0] addr;
    logic [17:0]   wdata;
    logic [17:0]   rdata;
    logic          dq_oe;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    // reference model state
    int          ms;       // 0 deselected, 1 read, 2 write
    bit          mfirst;
    logic [5:0]  mbase;
    logic [1:0]  mcnt;
    logic [17:0] mm [64];

    always #5 clk = ~clk;

    sram_ft #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .adv_ld_n(adv_ld_n), .we_n(we_n), .bws_n(bws_n),
        .addr(addr), .mode(mode), .oe_n(oe_n), .wdata(wdata),
        .rdata(rdata), .dq_oe(dq_oe)
    );

    function automatic logic [5:0] mcur();
        logic [1:0] lo;
        lo = mode ? (mbase[1:0] ^ mcnt) : (mbase[1:0] + mcnt);
        return {mbase[5:2], lo};
    endfunction

    task automatic model_edge();
        logic [17:0] mask;
        bit          nfirst;
        if (cen_n) return;
        if (ms == 2) begin
            mask = {~bws_n[1], ~bws_n[0], {8{~bws_n[1]}}, {8{~bws_n[0]}}};
            mm[mcur()] = (mm[mcur()] & ~mask) | (wdata & mask);
        end
        nfirst = (ms == 0);
        if (!adv_ld_n) begin
            if (!ce1_n && ce2 && !ce3_n) begin
                mbase = addr;
                mcnt  = 2'd0;
                ms    = we_n ? 1 : 2;
            end else begin
                ms = 0;
            end
        end else if (ms != 0) begin
            mcnt = mcnt + 2'd1;
        end
        mfirst = nfirst;
    endtask

    task automatic cyc(input logic c_n, input logic [2:0] ce, input logic adv,
                       input logic w_n, input logic [1:0] bw, input logic oe,
                       input logic md, input logic [5:0] a, input logic [17:0] wd);
        @(negedge clk);
        cen_n = c_n; {ce1_n, ce2, ce3_n} = ce; adv_ld_n = adv; we_n = w_n;
        bws_n = bw; oe_n = oe; mode = md; addr = a; wdata = wd;
        @(posedge clk);
        #1;
        model_edge();
    endtask

    task automatic check_model(input int req);
        logic exp_oe;
        exp_oe = !oe_n && (ms == 1) && !mfirst;
        checks++;
        if (dq_oe !== exp_oe) begin
            fails++;
            $display("FAIL R%0d dq_oe actual %b expected %b", req, dq_oe, exp_oe);
        end
        if (exp_oe) begin
            checks++;
            if (rdata !== mm[mcur()]) begin
                fails++;
                $display("FAIL R%0d rdata actual %h expected %h", req, rdata, mm[mcur()]);
            end
        end
    endtask

    task automatic check_lit(input string req, input logic exp_oe, input logic [17:0] exp_d);
        checks++;
        if (dq_oe !== exp_oe) begin
            fails++;
            $display("FAIL %s dq_oe actual %b expected %b", req, dq_oe, exp_oe);
        end
        if (exp_oe) begin
            checks++;
            if (rdata !== exp_d) begin
                fails++;
                $display("FAIL %s rdata actual %h expected %h", req, rdata, exp_d);
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cen_n = 1'b1; oe_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        ms = 0; mfirst = 1'b0; mbase = '0; mcnt = '0;
        check_lit("R1", 1'b0, 18'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; cen_n = 1'b1; ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
        adv_ld_n = 1'b0; we_n = 1'b1; bws_n = 2'b11; addr = '0; mode = 1'b1;
        oe_n = 1'b0; wdata = '0;
        do_reset();

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].cen_n, VEC[i].ce, VEC[i].adv, VEC[i].we_n, VEC[i].bws,
                VEC[i].oe_n, VEC[i].mode, VEC[i].a, VEC[i].wd);
            check_model(int'(VEC[i].req));
        end

        // R1: reset drops a pending write to word 20
        cyc(1'b0, ON, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 6'd20, 18'h0);
        do_reset();
        wdata = 18'h00000; bws_n = 2'b00;
        // R9: first read after reset is masked
        cyc(1'b0, ON, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 6'd20, 18'h0);
        check_lit("R9", 1'b0, 18'h0);
        // R6 lane merge kept, R1 no write leaked through reset
        cyc(1'b0, ON, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 6'd20, 18'h0);
        check_lit("R6", 1'b1, 18'h055CD);
        // R3 via ce1_n
        cyc(1'b0, 3'b110, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 6'd20, 18'h0);
        check_lit("R3", 1'b0, 18'h0);
        cyc(1'b0, ON, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 6'd7, 18'h0);
        check_lit("R9", 1'b0, 18'h0);
        // R5 word written in the data cycle of vector 29
        cyc(1'b0, ON, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 6'd7, 18'h0);
        check_lit("R5", 1'b1, 18'h3C3C3);
        // R3 via ce3_n
        cyc(1'b0, 3'b011, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 6'd7, 18'h0);
        check_lit("R3", 1'b0, 18'h0);
        // R10 linear from 34: 34(masked), 35, 32
        cyc(1'b0, ON, 1'b0, 1'b1, 2'b00, 1'b0, 1'b0, 6'd34, 18'h0);
        check_lit("R9", 1'b0, 18'h0);
        cyc(1'b0, ON, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 6'd0, 18'h0);
        check_lit("R10", 1'b1, 18'h00A04);
        cyc(1'b0, ON, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 6'd0, 18'h0);
        check_lit("R10", 1'b1, 18'h00A01);
        // R11 interleaved from 5: 5, 4, 7, 6
        cyc(1'b0, ON, 1'b0, 1'b1, 2'b00, 1'b0, 1'b1, 6'd5, 18'h0);
        check_lit("R11", 1'b1, 18'h34444);
        cyc(1'b0, ON, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 6'd0, 18'h0);
        check_lit("R11", 1'b1, 18'h23333);
        cyc(1'b0, ON, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 6'd0, 18'h0);
        check_lit("R11", 1'b1, 18'h3C3C3);
        // R7 stall holds word 7 on the outputs
        cyc(1'b1, ON, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 6'd0, 18'h3FFFF);
        check_lit("R7", 1'b1, 18'h3C3C3);
        cyc(1'b0, ON, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, 6'd0, 18'h0);
        check_lit("R11", 1'b1, 18'h01111);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule